// File: doc/BRIEF.md
# String Index Stepper with Direction and Interrupt-Enable Control

This unit keeps two control bits for a string-transfer datapath. One is a direction bit that sets the step sense of the index pointers. The other is an interrupt-enable bit that gates an external request line. The unit also holds two 16-bit index pointers: a read pointer and a write pointer.

Each clock the unit takes at most one command on `cmd_i`. A step command moves both pointers by the element size given on `size_i`. They move up when the direction bit is 0 and down when it is 1. The other commands set or clear one of the two control bits.

The read pointer is tied to the data segment and the write pointer to the extra segment. The unit forms a 20-bit physical address for each pair from the segment value and the offset. Memory access, fetch and repeat looping belong to the unit's neighbours.

Top module: `str_idx_unit`

## Requirements
- R1: While `rst_ni` is low, `dir_o`, `ie_o`, `src_idx_o` and `dst_idx_o` are all 0.
- R2: Command code 1 (`cmd_i`=3'd1) sets `dir_o` at the next rising clock edge. Command code 2 clears it at the next edge. No other command changes `dir_o`.
- R3: On command code 5 (step) with `dir_o`=0, both index pointers increase at the next edge by the element size, modulo 2^16. Size codes on `size_i` are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes.
- R4: On step with `dir_o`=1, both index pointers decrease by the element size, modulo 2^16. For example, 0 minus 1 gives 16'hFFFF.
- R5: A step with `size_i`=3 leaves both pointers unchanged. Any command other than step also leaves them unchanged.
- R6: Command code 3 sets `ie_o` at the next edge. Command code 4 clears it at the next edge. No other command changes `ie_o`.
- R7: `irq_o` follows `irq_i` in the same cycle when `ie_o`=1. It is 0 when `ie_o`=0.
- R8: `src_addr_o` = ({`ds_seg_i`, 4'b0} + `src_idx_o`) mod 2^20. It is combinational in the segment input.
- R9: `dst_addr_o` = ({`es_seg_i`, 4'b0} + `dst_idx_o`) mod 2^20.
- R10: Command codes 0, 6 and 7 change neither control bit nor either pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code: 0 none, 1 set dir, 2 clear dir, 3 set ie, 4 clear ie, 5 step |
| size_i | input | 2 | Element size for step: 0 byte, 1 half, 2 word, 3 no step |
| ds_seg_i | input | 16 | Data segment value |
| es_seg_i | input | 16 | Extra segment value |
| irq_i | input | 1 | External interrupt request |
| dir_o | output | 1 | Direction bit (1 = decrement) |
| ie_o | output | 1 | Interrupt-enable bit |
| irq_o | output | 1 | Gated interrupt request |
| src_idx_o | output | 16 | Read index pointer |
| dst_idx_o | output | 16 | Write index pointer |
| src_addr_o | output | 20 | Read physical address |
| dst_addr_o | output | 20 | Write physical address |

## Verification
The bench drives pointer wrap in both directions: decrement from 0 and increment across 16'hFFFF. A design that dropped the modulo arithmetic or stepped the wrong way would show pointers far from 16'hFFFF or 16'h0001.

It also issues steps with size code 3 and the undefined codes 6 and 7. A design that treated size 3 as a 4-byte step, or decoded the spare codes as flag commands, would move a pointer or flip a bit.

Segment values near 16'hFFFF are paired with large offsets. An address adder that lost the carry truncation or shifted by the wrong amount would disagree in the upper nibble.

Requests are toggled with the enable bit in both states, to catch a gate that passes a request while the bit is clear.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_DIR_DN = 3'd1,
    CMD_DIR_UP = 3'd2,
    CMD_IE_ON  = 3'd3,
    CMD_IE_OFF = 3'd4,
    CMD_STEP   = 3'd5
  } sis_cmd_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } sis_size_e;

  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: step_bytes = 3'd1;
      SZ_HALF: step_bytes = 3'd2;
      SZ_WORD: step_bytes = 3'd4;
      default: step_bytes = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/sis_flag_ctl.sv
module sis_flag_ctl
  import sis_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cmd_i,
  input  logic       irq_i,
  output logic       dir_o,
  output logic       ie_o,
  output logic       irq_o
);
  logic dir_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      case (cmd_i)
        CMD_DIR_DN: dir_q <= 1'b1;
        CMD_DIR_UP: dir_q <= 1'b0;
        CMD_IE_ON:  ie_q  <= 1'b1;
        CMD_IE_OFF: ie_q  <= 1'b0;
        default: ;
      endcase
    end
  end

  assign dir_o = dir_q;
  assign ie_o  = ie_q;
  assign irq_o = irq_i & ie_q;
endmodule

// File: rtl/sis_idx_ptr.sv
module sis_idx_ptr #(
  parameter int IDX_W = 16,
  parameter int AMT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dec_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, idx_d, amt_ext;

  assign amt_ext = IDX_W'(amt_i);

  always_comb begin
    idx_d = idx_q;
    if (step_i) idx_d = dec_i ? idx_q - amt_ext : idx_q + amt_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= idx_d;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/sis_addr_gen.sv
module sis_addr_gen #(
  parameter int SEG_W   = 16,
  parameter int IDX_W   = 16,
  parameter int ADDR_W  = 20,
  parameter int SEG_SHL = 4
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [IDX_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int BASE_W = SEG_W + SEG_SHL;
  localparam int W0     = (BASE_W > IDX_W) ? BASE_W : IDX_W;
  localparam int SUM_W  = ((W0 + 1) > ADDR_W) ? (W0 + 1) : ADDR_W;

  logic [SUM_W-1:0] base, sum;

  assign base   = SUM_W'({seg_i, {SEG_SHL{1'b0}}});
  assign sum    = base + SUM_W'(off_i);
  assign addr_o = sum[ADDR_W-1:0];
endmodule

// File: rtl/str_idx_unit.sv
module str_idx_unit
  import sis_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int SEG_W   = 16,
  parameter int ADDR_W  = 20,
  parameter int SEG_SHL = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [1:0]        size_i,
  input  logic [SEG_W-1:0]  ds_seg_i,
  input  logic [SEG_W-1:0]  es_seg_i,
  input  logic              irq_i,
  output logic              dir_o,
  output logic              ie_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o
);
  localparam int N_PTR = 2;  // 0: read/data seg, 1: write/extra seg
  localparam int AMT_W = 3;

  logic             dir;
  logic             do_step;
  logic [AMT_W-1:0] amt;
  logic [SEG_W-1:0]  seg  [N_PTR];
  logic [IDX_W-1:0]  idx  [N_PTR];
  logic [ADDR_W-1:0] addr [N_PTR];

  sis_flag_ctl u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_i),
    .irq_i  (irq_i),
    .dir_o  (dir),
    .ie_o   (ie_o),
    .irq_o  (irq_o)
  );

  assign amt     = step_bytes(size_i);
  assign do_step = (cmd_i == CMD_STEP) && (amt != '0);

  assign seg[0] = ds_seg_i;
  assign seg[1] = es_seg_i;

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    sis_idx_ptr #(.IDX_W(IDX_W), .AMT_W(AMT_W)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (do_step),
      .dec_i  (dir),
      .amt_i  (amt),
      .idx_o  (idx[g])
    );
    sis_addr_gen #(.SEG_W(SEG_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SEG_SHL(SEG_SHL)) u_agen (
      .seg_i  (seg[g]),
      .off_i  (idx[g]),
      .addr_o (addr[g])
    );
  end

  assign dir_o      = dir;
  assign src_idx_o  = idx[0];
  assign dst_idx_o  = idx[1];
  assign src_addr_o = addr[0];
  assign dst_addr_o = addr[1];
endmodule

// File: rtl/sis_chk.sv
module sis_chk
  import sis_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       cmd_i,
  input logic [1:0]       size_i,
  input logic             irq_i,
  input logic             dir_o,
  input logic             ie_o,
  input logic             irq_o,
  input logic [IDX_W-1:0] src_idx_o,
  input logic [IDX_W-1:0] dst_idx_o
);
  p_dir_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_DIR_DN |=> dir_o);
  p_dir_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_DIR_UP |=> !dir_o);
  p_ie_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_IE_ON |=> ie_o);
  p_ie_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_IE_OFF |=> !ie_o);
  p_irq_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_o |-> !irq_o);
  p_irq_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_o |-> irq_o == irq_i);
  p_inc_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_STEP && !dir_o && size_i == SZ_BYTE)
      |=> src_idx_o == IDX_W'($past(src_idx_o) + 1'b1));
  p_dec_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_STEP && dir_o && size_i == SZ_BYTE)
      |=> dst_idx_o == IDX_W'($past(dst_idx_o) - 1'b1));
  p_idx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_STEP || size_i == SZ_NONE)
      |=> $stable(src_idx_o) && $stable(dst_idx_o));
  p_spare_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i > CMD_STEP || cmd_i == CMD_NONE) |=> $stable(dir_o) && $stable(ie_o));
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !dir_o && !ie_o && src_idx_o == '0 && dst_idx_o == '0);
endmodule

bind str_idx_unit sis_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_i     (cmd_i),
  .size_i    (size_i),
  .irq_i     (irq_i),
  .dir_o     (dir_o),
  .ie_o      (ie_o),
  .irq_o     (irq_o),
  .src_idx_o (src_idx_o),
  .dst_idx_o (dst_idx_o)
);

// File: tb/str_idx_unit_bench.sv
module str_idx_unit_bench;
  import sis_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = '0;
  logic [1:0]  size = '0;
  logic [15:0] ds = '0, es = '0;
  logic        irq = 1'b0;
  logic        dir, ie, irq_g;
  logic [15:0] sidx, didx;
  logic [19:0] saddr, daddr;

  int total = 0;
  int fails = 0;

  logic        m_dir = 1'b0, m_ie = 1'b0;
  logic [15:0] m_src = '0, m_dst = '0;

  always #4 clk = ~clk;

  str_idx_unit u_str_idx_unit (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .size_i(size),
    .ds_seg_i(ds), .es_seg_i(es), .irq_i(irq),
    .dir_o(dir), .ie_o(ie), .irq_o(irq_g),
    .src_idx_o(sidx), .dst_idx_o(didx),
    .src_addr_o(saddr), .dst_addr_o(daddr)
  );

  function automatic logic [19:0] exp_addr(input logic [15:0] seg, input logic [15:0] off);
    logic [20:0] s;
    s = {1'b0, seg, 4'h0} + {5'h0, off};
    return s[19:0];
  endfunction

  function automatic int unsigned size_amt(input logic [1:0] sz);
    case (sz)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; applies one command and checks the result one negedge later
  task automatic cyc(input logic [2:0] c, input logic [1:0] sz, input logic rq,
                     input logic [15:0] d, input logic [15:0] e);
    string t_idx, t_dir, t_ie;
    int unsigned a;
    cmd = c; size = sz; irq = rq; ds = d; es = e;
    #1;
    chk(irq_g == (rq & m_ie), "R7", 32'(irq_g), 32'(rq & m_ie));
    chk(saddr == exp_addr(d, m_src), "R8", 32'(saddr), 32'(exp_addr(d, m_src)));
    chk(daddr == exp_addr(e, m_dst), "R9", 32'(daddr), 32'(exp_addr(e, m_dst)));
    t_dir = (c > 3'd5 || c == 3'd0) ? "R10" : "R2";
    t_ie  = (c > 3'd5 || c == 3'd0) ? "R10" : "R6";
    a = size_amt(sz);
    if (c == 3'd5 && a != 0) begin
      t_idx = m_dir ? "R4" : "R3";
      if (m_dir) begin m_src = m_src - 16'(a); m_dst = m_dst - 16'(a); end
      else       begin m_src = m_src + 16'(a); m_dst = m_dst + 16'(a); end
    end else begin
      t_idx = (c > 3'd5 || c == 3'd0) ? "R10" : "R5";
    end
    case (c)
      3'd1: m_dir = 1'b1;
      3'd2: m_dir = 1'b0;
      3'd3: m_ie  = 1'b1;
      3'd4: m_ie  = 1'b0;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    chk(dir == m_dir, t_dir, 32'(dir), 32'(m_dir));
    chk(ie == m_ie, t_ie, 32'(ie), 32'(m_ie));
    chk(sidx == m_src, t_idx, 32'(sidx), 32'(m_src));
    chk(didx == m_dst, t_idx, 32'(didx), 32'(m_dst));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(dir == 1'b0 && ie == 1'b0, "R1", {30'b0, dir, ie}, 32'h0);
    chk(sidx == 16'h0 && didx == 16'h0, "R1", {sidx, didx}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // decrement wrap from zero (R4)
    cyc(3'd1, 2'd0, 1'b0, 16'h1000, 16'h2000);
    cyc(3'd5, 2'd0, 1'b0, 16'h1000, 16'h2000);   // -> FFFF
    cyc(3'd5, 2'd2, 1'b0, 16'hFFFF, 16'hFFFF);   // -> FFFB, address carry truncation
    // increment wrap (R3)
    cyc(3'd2, 2'd0, 1'b0, 16'hFFFF, 16'hF000);
    cyc(3'd5, 2'd2, 1'b0, 16'hFFFF, 16'hF000);   // -> FFFF
    cyc(3'd5, 2'd1, 1'b1, 16'h0000, 16'hFFF0);   // -> 0001
    // size code 3 and spare commands (R5, R10)
    cyc(3'd5, 2'd3, 1'b1, 16'h1234, 16'h5678);
    cyc(3'd6, 2'd0, 1'b1, 16'h1234, 16'h5678);
    cyc(3'd7, 2'd1, 1'b0, 16'h1234, 16'h5678);
    cyc(3'd0, 2'd2, 1'b1, 16'h1234, 16'h5678);
    // interrupt gating (R6, R7)
    cyc(3'd3, 2'd0, 1'b1, 16'h0, 16'h0);
    cyc(3'd0, 2'd0, 1'b1, 16'h0, 16'h0);
    cyc(3'd7, 2'd0, 1'b0, 16'h0, 16'h0);
    cyc(3'd4, 2'd0, 1'b1, 16'h0, 16'h0);
    cyc(3'd0, 2'd0, 1'b1, 16'h0, 16'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c;
      c = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'd5;
      cyc(c, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
          16'($urandom()), 16'($urandom()));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule